// File: doc/BRIEF.md
# Parameter-Filtered Associative Search Memory

This block is a small associative memory for 14-bit words. Every entry keeps its data word together with a 4-bit signature (the "parameter") derived from that word at write time. A lookup first checks the signature of the search word against all stored signatures in one cycle. Only the entries whose signature agrees (the candidates) then get a full 14-bit data compare, one candidate per cycle in ascending address order. When nothing agrees, the full compare stage is skipped.

The signature function is chosen when the block is built. A population-count function gives the number of set bits. A block-parity function folds four slices of the word into four bits and remaps the one reserved code. Signature value 4'b1111 is never produced for real data, so it serves as the marker for an empty entry. The result reports a hit flag, the lowest matching address and the number of full compares that were done, which lets the system see how well the filter worked.

Top module: `pcam_filter`

## Requirements
- R1: A write with `wr_en` high while `srch_ready` is high stores `wr_data` and its signature at `wr_addr` at that clock edge; a later search for that word finds it.
- R2: A write presented while `srch_ready` is low (a search in progress) is ignored and leaves the entry unchanged.
- R3: After reset every entry holds signature 4'b1111 (empty); any search then misses with a compare count of 0.
- R4: With `MODE` = 0 the signature is the binary count of one bits in the word (0 to 14).
- R5: With `MODE` = 1 the signature bits are the XOR of data bits [13:10] (bit 3), [9:6] (bit 2), [5:3] (bit 1) and [2:0] (bit 0); when these give 4'b1111 the signature becomes data bits [13:10] instead.
- R6: The signature of a written word or a search word is never 4'b1111.
- R7: When no stored signature equals the search signature, the result is a miss with a compare count of 0, and it is valid two edges after acceptance.
- R8: `res_cmps` equals the number of stored entries whose signature equals the search signature; a hit implies a nonzero count.
- R9: On a hit, `res_addr` is the lowest address whose stored data equals the search word.
- R10: `srch_ready` is high only while the block is idle; a search is accepted on an edge where `srch_valid` and `srch_ready` are both high, and `srch_ready` is low in the following cycle.
- R11: `res_valid` is high for exactly one cycle, in the cycle after the (1+K)-th edge following acceptance, where K is the candidate count of R8; `srch_ready` is high again in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write request |
| wr_addr | input | AW | Entry address to write |
| wr_data | input | DATA_W | Word to store |
| srch_valid | input | 1 | Search request |
| srch_data | input | DATA_W | Word to look up |
| srch_ready | output | 1 | Block idle, search and write accepted |
| res_valid | output | 1 | Result pulse |
| res_hit | output | 1 | At least one entry equals the search word |
| res_addr | output | AW | Lowest matching address (0 on a miss) |
| res_cmps | output | CW | Number of full data compares done |

## Verification
A search accepted on edge 0 spends edge 1 on the signature check and edges 2 to 1+K on its K candidates, so its result is due in the cycle after edge 1+K, with K counted by the bench from its own model of the stored signatures. The driver stamps each expected result with its acceptance cycle and K. The monitor samples on falling edges and checks that the pulse arrives exactly 1+K edges later, that no pulse arrives with nothing expected, and that the hit, the address and the count agree. Writes are driven and checked on falling edges as well, so a write counts as accepted only when the bench saw `srch_ready` high before the edge.

// File: rtl/pcam_pkg.sv
package pcam_pkg;
   localparam int EXT_ONES = 0;
   localparam int EXT_BXOR = 1;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_PARAM = 2'd1,
      ST_DATA  = 2'd2,
      ST_DONE  = 2'd3
   } seek_state_t;
endpackage

// File: rtl/pcam_extract.sv
module pcam_extract #(
   parameter int DATA_W = 14,
   parameter int PAR_W  = 4,
   parameter int MODE   = pcam_pkg::EXT_BXOR
) (
   input  logic [DATA_W-1:0] din,
   output logic [PAR_W-1:0]  sig
);
   generate
      if (MODE == pcam_pkg::EXT_ONES) begin : g_ones
         if (DATA_W >= (1 << PAR_W) - 1) begin : g_bad_ones
            $error("population count would reach the reserved code");
         end
         always_comb begin
            sig = '0;
            for (int i = 0; i < DATA_W; i++)
               sig = sig + PAR_W'(din[i]);
         end
      end else begin : g_bxor
         if (DATA_W != 14 || PAR_W != 4) begin : g_bad_bxor
            $error("block parity layout needs 14 data bits and 4 signature bits");
         end
         logic [3:0] fold;
         assign fold = {^din[13:10], ^din[9:6], ^din[5:3], ^din[2:0]};
         assign sig  = (fold == 4'hF) ? din[13:10] : fold;
      end
   endgenerate
endmodule

// File: rtl/pcam_store.sv
module pcam_store #(
   parameter int DEPTH  = 8,
   parameter int DATA_W = 14,
   parameter int PAR_W  = 4,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [PAR_W-1:0]  wsig,
   output logic [DATA_W-1:0] data_q [DEPTH],
   output logic [PAR_W-1:0]  sig_q  [DEPTH]
);
   generate
      for (genvar e = 0; e < DEPTH; e++) begin : g_ent
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               data_q[e] <= '0;
               sig_q[e]  <= '1;
            end else if (we && waddr == AW'(e)) begin
               data_q[e] <= wdata;
               sig_q[e]  <= wsig;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/pcam_seek.sv
module pcam_seek #(
   parameter int DEPTH  = 8,
   parameter int DATA_W = 14,
   parameter int PAR_W  = 4,
   localparam int AW    = $clog2(DEPTH),
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DATA_W-1:0] key_in,
   input  logic [PAR_W-1:0]  key_sig_in,
   input  logic [DATA_W-1:0] data_q [DEPTH],
   input  logic [PAR_W-1:0]  sig_q  [DEPTH],
   output logic              idle,
   output logic              done,
   output logic              hit,
   output logic [AW-1:0]     addr,
   output logic [CW-1:0]     cmps
);
   import pcam_pkg::*;

   seek_state_t       state;
   logic [DATA_W-1:0] key;
   logic [PAR_W-1:0]  key_sig;
   logic [DEPTH-1:0]  cand, cand_rest, sig_eq;
   logic [AW-1:0]     pick;

   generate
      for (genvar e = 0; e < DEPTH; e++) begin : g_cmp
         assign sig_eq[e] = (sig_q[e] == key_sig);
      end
   endgenerate

   always_comb begin
      pick = '0;
      for (int i = DEPTH - 1; i >= 0; i--)
         if (cand[i]) pick = AW'(i);
      cand_rest       = cand;
      cand_rest[pick] = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         key     <= '0;
         key_sig <= '1;
         cand    <= '0;
         hit     <= 1'b0;
         addr    <= '0;
         cmps    <= '0;
      end else begin
         case (state)
            ST_IDLE: if (start) begin
               key     <= key_in;
               key_sig <= key_sig_in;
               state   <= ST_PARAM;
            end
            ST_PARAM: begin
               cand  <= sig_eq;
               hit   <= 1'b0;
               addr  <= '0;
               cmps  <= '0;
               state <= (|sig_eq) ? ST_DATA : ST_DONE;
            end
            ST_DATA: begin
               cand <= cand_rest;
               cmps <= cmps + CW'(1);
               if (!hit && data_q[pick] == key) begin
                  hit  <= 1'b1;
                  addr <= pick;
               end
               if (cand_rest == '0) state <= ST_DONE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign idle = (state == ST_IDLE);
   assign done = (state == ST_DONE);
endmodule

// File: rtl/pcam_filter.sv
module pcam_filter #(
   parameter int DEPTH  = 8,
   parameter int DATA_W = 14,
   parameter int PAR_W  = 4,
   parameter int MODE   = pcam_pkg::EXT_BXOR,
   localparam int AW    = $clog2(DEPTH),
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              srch_valid,
   input  logic [DATA_W-1:0] srch_data,
   output logic              srch_ready,
   output logic              res_valid,
   output logic              res_hit,
   output logic [AW-1:0]     res_addr,
   output logic [CW-1:0]     res_cmps
);
   generate
      if (DEPTH < 2 || DEPTH > 256) begin : g_bad_depth
         $error("DEPTH must lie in 2..256");
      end
      if (MODE != pcam_pkg::EXT_ONES && MODE != pcam_pkg::EXT_BXOR) begin : g_bad_mode
         $error("MODE selects no known signature function");
      end
   endgenerate

   logic [PAR_W-1:0]  wr_par, srch_par;
   logic [DATA_W-1:0] data_q [DEPTH];
   logic [PAR_W-1:0]  sig_q  [DEPTH];
   logic              idle;

   pcam_extract #(.DATA_W(DATA_W), .PAR_W(PAR_W), .MODE(MODE)) u_ext_wr (
      .din(wr_data), .sig(wr_par));

   pcam_extract #(.DATA_W(DATA_W), .PAR_W(PAR_W), .MODE(MODE)) u_ext_key (
      .din(srch_data), .sig(srch_par));

   pcam_store #(.DEPTH(DEPTH), .DATA_W(DATA_W), .PAR_W(PAR_W)) u_store (
      .clk(clk), .rst_n(rst_n), .we(wr_en && idle), .waddr(wr_addr),
      .wdata(wr_data), .wsig(wr_par), .data_q(data_q), .sig_q(sig_q));

   pcam_seek #(.DEPTH(DEPTH), .DATA_W(DATA_W), .PAR_W(PAR_W)) u_seek (
      .clk(clk), .rst_n(rst_n), .start(srch_valid), .key_in(srch_data),
      .key_sig_in(srch_par), .data_q(data_q), .sig_q(sig_q), .idle(idle),
      .done(res_valid), .hit(res_hit), .addr(res_addr), .cmps(res_cmps));

   assign srch_ready = idle;
endmodule

// File: rtl/pcam_sva.sv
module pcam_sva #(
   parameter int DEPTH = 8,
   parameter int PAR_W = 4,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [PAR_W-1:0] wr_par,
   input logic             srch_valid,
   input logic [PAR_W-1:0] srch_par,
   input logic             srch_ready,
   input logic             res_valid,
   input logic             res_hit,
   input logic [CW-1:0]    res_cmps
);
   a_r6_write_sig_free: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> wr_par != '1);

   a_r6_key_sig_free: assert property (@(posedge clk) disable iff (!rst_n)
      srch_valid |-> srch_par != '1);

   a_r10_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (srch_valid && srch_ready) |=> !srch_ready);

   a_r7_filter_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (srch_valid && srch_ready) |=> !res_valid);

   a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> (!res_valid && srch_ready));

   a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> res_cmps <= CW'(DEPTH));

   a_r8_hit_compared: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_hit) |-> res_cmps != '0);
endmodule

bind pcam_filter pcam_sva #(.DEPTH(DEPTH), .PAR_W(PAR_W)) u_sva (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_par(wr_par),
   .srch_valid(srch_valid), .srch_par(srch_par), .srch_ready(srch_ready),
   .res_valid(res_valid), .res_hit(res_hit), .res_cmps(res_cmps));

// File: tb/sim_pcam_filter.sv
module sim_pcam_filter;
   localparam int DEPTH = 8;
   localparam int AW    = 3;
   localparam int CW    = 4;

   typedef struct {
      logic   hit;
      int     addr;
      int     cmps;
      longint acc;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [13:0] wr_data = '0;
   logic srch_valid = 1'b0;
   logic [13:0] srch_data = '0;

   logic          rdy [2];
   logic          rv  [2];
   logic          rh  [2];
   logic [AW-1:0] ra  [2];
   logic [CW-1:0] rc  [2];

   int errors = 0;
   int checks = 0;
   longint cyc = 0;
   exp_t q0[$];
   exp_t q1[$];

   logic [13:0] m_data [DEPTH];
   logic [3:0]  m_sig  [2][DEPTH];

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   // unit 0: block parity signature, unit 1: population count
   pcam_filter #(.DEPTH(DEPTH), .MODE(1)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .srch_valid(srch_valid), .srch_data(srch_data), .srch_ready(rdy[0]),
      .res_valid(rv[0]), .res_hit(rh[0]), .res_addr(ra[0]), .res_cmps(rc[0]));

   pcam_filter #(.DEPTH(DEPTH), .MODE(0)) u1 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .srch_valid(srch_valid), .srch_data(srch_data), .srch_ready(rdy[1]),
      .res_valid(rv[1]), .res_hit(rh[1]), .res_addr(ra[1]), .res_cmps(rc[1]));

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic logic [3:0] sig_of(input int m, input logic [13:0] d);
      logic [3:0] f;
      if (m == 1) return 4'($countones(d));
      f = {^d[13:10], ^d[9:6], ^d[5:3], ^d[2:0]};
      return (f == 4'hF) ? d[13:10] : f;
   endfunction

   function automatic exp_t predict(input int m, input logic [13:0] key, input longint acc);
      exp_t e;
      logic [3:0] ks = sig_of(m, key);
      e.hit = 1'b0; e.addr = 0; e.cmps = 0; e.acc = acc;
      for (int i = 0; i < DEPTH; i++) begin
         if (m_sig[m][i] == ks) begin
            e.cmps++;
            if (!e.hit && m_data[i] == key) begin
               e.hit = 1'b1;
               e.addr = i;
            end
         end
      end
      return e;
   endfunction

   task automatic wait_idle();
      @(negedge clk);
      while (!(rdy[0] && rdy[1])) @(negedge clk);
   endtask

   // R1: write while idle, model updated
   task automatic do_write(input int a, input logic [13:0] d);
      wait_idle();
      wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
      m_data[a] = d;
      for (int m = 0; m < 2; m++) m_sig[m][a] = sig_of(m, d);
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic start_search(input logic [13:0] key);
      wait_idle();
      srch_valid = 1'b1; srch_data = key;
      q0.push_back(predict(0, key, cyc + 1));
      q1.push_back(predict(1, key, cyc + 1));
      @(posedge clk);
      @(negedge clk);
      srch_valid = 1'b0;
      chk("R10", "ready after accept u0", rdy[0], 0);
      chk("R10", "ready after accept u1", rdy[1], 0);
   endtask

   // monitor: pop and compare on each result pulse
   always @(negedge clk) begin
      for (int m = 0; m < 2; m++) begin
         if (rst_n && rv[m]) begin
            exp_t e;
            if ((m == 0 ? q0.size() : q1.size()) == 0) begin
               chk("R11", "unexpected result pulse", 1, 0);
            end else begin
               e = (m == 0) ? q0.pop_front() : q1.pop_front();
               chk("R11", $sformatf("latency u%0d", m), cyc - e.acc, 1 + e.cmps);
               chk("R8",  $sformatf("compare count u%0d", m), rc[m], e.cmps);
               chk("R9",  $sformatf("hit u%0d", m), rh[m], e.hit);
               if (e.hit) chk("R9", $sformatf("address u%0d", m), ra[m], e.addr);
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [31:0] lcg = 32'h1234_5678;
      for (int i = 0; i < DEPTH; i++) begin
         m_data[i] = '0; m_sig[0][i] = 4'hF; m_sig[1][i] = 4'hF;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R3", "ready after reset", rdy[0] && rdy[1], 1);
      chk("R3", "no result after reset", rv[0] || rv[1], 0);

      // R3 and R7: empty memory misses with zero compares
      start_search(14'h0000);
      start_search(14'h3FFF);

      // R4/R5 signature corner cases
      do_write(0, 14'h0155);
      do_write(1, 14'h0449);   // parity folds to 1111, remapped to 0001 (R5)
      do_write(2, 14'h3FFF);   // 14 ones (R4)
      do_write(5, 14'h0155);   // duplicate, higher address (R9)
      do_write(4, 14'h0001);   // parity 0001, same as remapped entry (R5)
      start_search(14'h0155);
      start_search(14'h0449);
      start_search(14'h0001);
      start_search(14'h3FFF);
      start_search(14'h2AAA);
      start_search(14'h0000);

      // R2: write during a busy search is ignored
      start_search(14'h0155);
      wr_en = 1'b1; wr_addr = 3'd6; wr_data = 14'h1234;
      chk("R2", "busy during write", rdy[0] || rdy[1], 0);
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
      start_search(14'h1234);
      do_write(6, 14'h1234);   // R1: accepted when idle
      start_search(14'h1234);

      // R9: overwrite lowest duplicate, next one must be reported
      do_write(0, 14'h0ABC);
      start_search(14'h0155);

      // mixed traffic
      for (int n = 0; n < 40; n++) begin
         lcg = lcg * 32'd1664525 + 32'd1013904223;
         if (lcg[31]) do_write(int'(lcg[10:8]), lcg[23:10] & 14'h00FF);
         else start_search(lcg[23:10] & 14'h00FF);
      end

      wait_idle();
      repeat (20) @(negedge clk);
      chk("R11", "results outstanding u0", q0.size(), 0);
      chk("R11", "results outstanding u1", q1.size(), 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule